// File: doc/BRIEF.md
# Serial master transfer delay sequencer

This block is the timing core of a serial-peripheral master. Software programs a 16-bit control word and sets its start bit. The block then accepts one command through a valid/ready handshake. Each command carries a 16-bit data word and two delay-enable flags. The block pulls the active-low chip select, waits a lead time, and shifts the word out MSB first while it shifts a reply in. It then releases chip select and waits a trailing time. At the end it clears the start bit by itself.

The serial clock idles low. Output data changes on the rising (leading) edge, and input data is sampled on the falling (trailing) edge. The serial clock is the system clock divided by a fixed parameter. All delays are counted in system clock cycles. Software can abort a running transfer by clearing the start bit. An abort-lock input turns that clear into a no-op.

Top module: `spi_delay_seq`

## Requirements
- R1: After reset the control word reads 0x0404 (start bit 0, lead field 4, trail field 4). busy and cmd_ready are 0, cs_n is 1 and sclk is 0.
- R2: The control word has the start bit at bit 15, the lead-delay field in bits 14:8 and the trailing-delay field in bits 7:0. A write stores all three. A read returns the stored value on the same cycle.
- R3: Writing the start bit as 1 makes busy 1. cmd_ready is 1 while busy is 1 and no command is in progress. A handshake (cmd_valid and cmd_ready high at one clock edge) pulls cs_n low one cycle later.
- R4: With cmd_lead_en = 1, the first sclk rising edge comes L system cycles after cs_n falls. L is the lead field, and a field of 0 gives L = 128.
- R5: With cmd_trail_en = 1, busy falls T system cycles after cs_n rises. T is the trail field as stored when the shift ends, and a field of 0 gives T = 256.
- R6: When a command's enable flag for a delay is 0, that delay is CLK_DIV/2 cycles (2 by default), whatever the field holds.
- R7: Exactly 16 sclk pulses occur, with period CLK_DIV cycles, high for the first half. mosi carries cmd_tx_word MSB first. mosi changes only at a rising edge and holds through the following falling edge. sclk is high only while cs_n is low.
- R8: miso is sampled at each falling sclk edge, MSB first. When the last bit ends, rx_word takes the received word and rx_valid is high for one cycle, in the same cycle that cs_n goes high.
- R9: At the end of the trailing delay the start bit clears by itself and busy falls.
- R10: Writing the start bit as 0 while busy and abort_lock = 0 aborts the transfer. On the next cycle cs_n is 1, sclk is 0 and busy is 0. No rx_valid pulse follows and rx_word keeps its earlier value.
- R11: While abort_lock = 1, writing the start bit as 0 leaves it at 1 and the transfer completes normally. The two delay fields of that write are still stored.
- R12: If a write setting the start bit falls in the same cycle as the automatic clear, the write wins. busy stays 1 and cmd_ready is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| abort_lock | input | 1 | When high, a software clear of the start bit is ignored |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block accepts a command |
| cmd_lead_en | input | 1 | Command uses the programmed lead delay |
| cmd_trail_en | input | 1 | Command uses the programmed trailing delay |
| cmd_tx_word | input | 16 | Word to transmit |
| rx_word | output | 16 | Last completely received word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| busy | output | 1 | Mirror of the start bit |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two things can act on the start bit in one cycle: a software write and the hardware clear at the end of the trailing delay. The bench measures the trailing delay from the rising edge of cs_n, then places a write setting the start bit so that it is held across exactly the clock edge that ends the delay. It judges the outcome by busy and cmd_ready staying high on the next cycle. A second collision is a software clear that lands during shifting while abort_lock is high. The bench judges it by the unchanged start bit, the newly stored trail field, and the trailing delay measured at the pins.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_t;

  function automatic int unsigned wider(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_dly_ctrlreg.sv
module spi_dly_ctrlreg #(
  parameter int LEAD_W    = 7,
  parameter int TRAIL_W   = 8,
  parameter int RST_LEAD  = 4,
  parameter int RST_TRAIL = 4,
  localparam int REG_W    = 1 + LEAD_W + TRAIL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  input  logic               lock,
  input  logic               hw_clear,
  output logic               en,
  output logic [LEAD_W-1:0]  lead_f,
  output logic [TRAIL_W-1:0] trail_f,
  output logic               sw_abort
);

  localparam int EN_POS = REG_W - 1;

  logic               en_q, en_d;
  logic [LEAD_W-1:0]  lead_q, lead_d;
  logic [TRAIL_W-1:0] trail_q, trail_d;

  // software clear of a running transfer, honoured only without the lock
  assign sw_abort = we && !wdata[EN_POS] && en_q && !lock;

  always_comb begin
    en_d    = en_q;
    lead_d  = lead_q;
    trail_d = trail_q;
    if (we) begin
      lead_d  = wdata[EN_POS-1 -: LEAD_W];
      trail_d = wdata[TRAIL_W-1:0];
      en_d    = wdata[EN_POS] || (en_q && lock);
    end else if (hw_clear) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lead_q  <= LEAD_W'(RST_LEAD);
      trail_q <= TRAIL_W'(RST_TRAIL);
    end else begin
      en_q    <= en_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign en      = en_q;
  assign lead_f  = lead_q;
  assign trail_f = trail_q;

  p_lock_keeps_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[EN_POS] && lock && en_q) |=> en_q);

  p_write_beats_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[EN_POS] && hw_clear) |=> en_q);

endmodule

// File: rtl/spi_dly_timer.sv
module spi_dly_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // a running delay phase never sees an empty counter (R4, R5)
  p_cnt_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));

endmodule

// File: rtl/spi_dly_shifter.sv
module spi_dly_shifter #(
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              active,
  input  logic              advance,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              last,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int HALF  = CLK_DIV / 2;

  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic              rxv_q, rxv_d;
  logic              ph_end, samp;

  assign ph_end = (ph_q == PH_W'(CLK_DIV - 1));
  assign samp   = advance && (ph_q == PH_W'(HALF - 1));
  assign last   = advance && ph_end && (bit_q == BIT_W'(WORD_W - 1));

  always_comb begin
    ph_d  = ph_q;
    bit_d = bit_q;
    tx_d  = tx_q;
    sr_d  = sr_q;
    rx_d  = rx_q;
    rxv_d = 1'b0;
    if (start) begin
      ph_d  = '0;
      bit_d = '0;
      tx_d  = tx_word;
    end else if (advance) begin
      ph_d = ph_end ? '0 : ph_q + PH_W'(1);
      if (samp) sr_d = {sr_q[WORD_W-2:0], miso};
      if (ph_end) begin
        tx_d  = {tx_q[WORD_W-2:0], 1'b0};
        bit_d = bit_q + BIT_W'(1);
        if (last) begin
          rx_d  = sr_q;
          rxv_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      bit_q <= '0;
      tx_q  <= '0;
      sr_q  <= '0;
      rx_q  <= '0;
      rxv_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
      tx_q  <= tx_d;
      sr_q  <= sr_d;
      rx_q  <= rx_d;
      rxv_q <= rxv_d;
    end
  end

  assign sclk     = active && (ph_q < PH_W'(HALF));
  assign mosi     = active && tx_q[WORD_W-1];
  assign rx_word  = rx_q;
  assign rx_valid = rxv_q;

  // data only moves at the start of a bit, i.e. on the rising edge
  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (ph_q != '0)) |-> $stable(mosi));

endmodule

// File: rtl/spi_delay_seq.sv
module spi_delay_seq
  import spi_dly_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CLK_DIV  = 4,
  parameter int LEAD_W   = 7,
  parameter int TRAIL_W  = 8,
  localparam int REG_W   = 1 + LEAD_W + TRAIL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              abort_lock,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_lead_en,
  input  logic              cmd_trail_en,
  input  logic [WORD_W-1:0] cmd_tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int CNT_W = int'(wider(LEAD_W, TRAIL_W)) + 1;
  localparam int HALF  = CLK_DIV / 2;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic               en, hw_clear, sw_abort;
  logic [LEAD_W-1:0]  lead_f;
  logic [TRAIL_W-1:0] trail_f;

  spi_dly_ctrlreg #(
    .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W), .RST_LEAD(4), .RST_TRAIL(4)
  ) u_reg (
    .clk(clk), .rst_n(rst_n_i), .we(reg_we), .wdata(reg_wdata),
    .lock(abort_lock), .hw_clear(hw_clear), .en(en),
    .lead_f(lead_f), .trail_f(trail_f), .sw_abort(sw_abort)
  );

  seq_state_t st_q, st_d;
  logic       trail_en_q, trail_en_d;
  logic       tmr_load, tmr_run, tmr_expire;
  logic [CNT_W-1:0] tmr_val, lead_len, trail_len;
  logic       sh_start, sh_active, sh_advance, sh_last;

  // a zero field means the longest delay the field can express
  assign lead_len  = !cmd_lead_en ? CNT_W'(HALF) :
                     (lead_f == '0) ? CNT_W'(1 << LEAD_W) : CNT_W'(lead_f);
  assign trail_len = !trail_en_q ? CNT_W'(HALF) :
                     (trail_f == '0) ? CNT_W'(1 << TRAIL_W) : CNT_W'(trail_f);

  always_comb begin
    st_d       = st_q;
    trail_en_d = trail_en_q;
    tmr_load   = 1'b0;
    tmr_val    = lead_len;
    sh_start   = 1'b0;
    hw_clear   = 1'b0;
    if (sw_abort) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (en && cmd_valid) begin
          st_d       = ST_LEAD;
          tmr_load   = 1'b1;
          sh_start   = 1'b1;
          trail_en_d = cmd_trail_en;
        end
        ST_LEAD: if (tmr_expire) st_d = ST_SHIFT;
        ST_SHIFT: if (sh_last) begin
          st_d     = ST_TRAIL;
          tmr_load = 1'b1;
          tmr_val  = trail_len;
        end
        ST_TRAIL: if (tmr_expire) begin
          st_d     = ST_IDLE;
          hw_clear = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q       <= ST_IDLE;
      trail_en_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      trail_en_q <= trail_en_d;
    end
  end

  assign tmr_run    = ((st_q == ST_LEAD) || (st_q == ST_TRAIL)) && !sw_abort;
  assign sh_active  = (st_q == ST_SHIFT);
  assign sh_advance = sh_active && !sw_abort;

  spi_dly_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .expire(tmr_expire)
  );

  spi_dly_shifter #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_sh (
    .clk(clk), .rst_n(rst_n_i), .start(sh_start), .tx_word(cmd_tx_word),
    .active(sh_active), .advance(sh_advance), .miso(miso),
    .sclk(sclk), .mosi(mosi), .last(sh_last),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  assign reg_rdata = {en, lead_f, trail_f};
  assign busy      = en;
  assign cmd_ready = en && (st_q == ST_IDLE);
  assign cs_n      = (st_q == ST_IDLE) || (st_q == ST_TRAIL);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    !busy |-> (cs_n && !sclk));

  p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    sclk |-> !cs_n);

  p_rxv_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    rx_valid |-> (cs_n && $past(st_q == ST_SHIFT)));

  p_auto_clear_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((st_q == ST_TRAIL) && tmr_expire && !reg_we) |=> !busy);

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    sw_abort |=> (cs_n && !sclk && !busy && !rx_valid));

endmodule

// File: tb/sim_spi_delay_seq.sv
module sim_spi_delay_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        abort_lock = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_lead_en = 1'b0;
  logic        cmd_trail_en = 1'b0;
  logic [15:0] cmd_tx_word = '0;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic        busy, sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_delay_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .abort_lock(abort_lock), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_lead_en(cmd_lead_en), .cmd_trail_en(cmd_trail_en),
    .cmd_tx_word(cmd_tx_word), .rx_word(rx_word), .rx_valid(rx_valid),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // pin monitor and slave model, evaluated at each falling clk edge
  logic [15:0] slave_word = '0;
  logic [15:0] mosi_cap = '0;
  int cyc = 0, fall_cyc = 0, rise1_cyc = 0, rise_cyc = 0, bfall_cyc = 0, rxv_cyc = 0;
  int rises = 0, rxv_cnt = 0;
  bit mosi_bad = 1'b0, mosi_at_rise = 1'b0;
  bit prev_cs = 1'b1, prev_sclk = 1'b0, prev_busy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      fall_cyc = cyc; rises = 0; mosi_cap = '0; mosi_bad = 1'b0; rxv_cnt = 0;
    end
    if (!prev_sclk && sclk) begin
      if (rises == 0) rise1_cyc = cyc;
      mosi_at_rise = mosi;
      if (rises < 16) miso = slave_word[15-rises];
      rises++;
    end
    if (prev_sclk && !sclk) begin
      if (mosi != mosi_at_rise) mosi_bad = 1'b1;
      mosi_cap = {mosi_cap[14:0], mosi};
    end
    if (!prev_cs && cs_n) rise_cyc = cyc;
    if (prev_busy && !busy) bfall_cyc = cyc;
    if (rx_valid) begin rxv_cnt++; rxv_cyc = cyc; end
    prev_cs = cs_n; prev_sclk = sclk; prev_busy = busy;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  function automatic int exp_lead(bit en, int f);
    return en ? ((f == 0) ? 128 : f) : 2;
  endfunction

  function automatic int exp_trail(bit en, int f);
    return en ? ((f == 0) ? 256 : f) : 2;
  endfunction

  // offer one command and return the monitor cycle of the handshake
  task automatic launch(bit le, bit te, logic [15:0] tw, logic [15:0] sw, output int hs);
    slave_word = sw;
    while (!cmd_ready) tick();
    cmd_valid = 1'b1; cmd_lead_en = le; cmd_trail_en = te; cmd_tx_word = tw;
    hs = cyc;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic full_xfer(int lf, int tf, bit le, bit te, logic [15:0] tw, logic [15:0] sw);
    int hs;
    wr({1'b1, lf[6:0], tf[7:0]});
    launch(le, te, tw, sw, hs);
    while (busy) tick();
    tick();
    check("R3", "cs_n fall after handshake", fall_cyc - hs, 1);
    check(le ? "R4" : "R6", "lead cycles", rise1_cyc - fall_cyc, exp_lead(le, lf));
    check(te ? "R5" : "R6", "trail cycles", bfall_cyc - rise_cyc, exp_trail(te, tf));
    check("R7", "sclk pulses", rises, 16);
    check("R7", "mosi word", int'(mosi_cap), int'(tw));
    check("R7", "mosi moved between edges", int'(mosi_bad), 0);
    check("R8", "rx_word", int'(rx_word), int'(sw));
    check("R8", "rx_valid pulses", rxv_cnt, 1);
    check("R8", "rx_valid with cs_n release", rxv_cyc, rise_cyc);
    check("R9", "start bit after completion", int'(reg_rdata[15]), 0);
    check("R7", "sclk idle", int'(sclk), 0);
  endtask

  initial begin
    int hs;
    int unused_seed;
    logic [15:0] prev_rx;
    unused_seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    check("R1", "reset control word", int'(reg_rdata), 16'h0404);
    check("R1", "busy", int'(busy), 0);
    check("R1", "cmd_ready", int'(cmd_ready), 0);
    check("R1", "cs_n", int'(cs_n), 1);
    check("R1", "sclk", int'(sclk), 0);

    // R2 field storage and read-back
    wr(16'h2A7B);
    check("R2", "read back", int'(reg_rdata), 16'h2A7B);
    check("R2", "busy stays low", int'(busy), 0);

    // R3 start: waiting for a command with chip select released
    wr(16'h8505);
    check("R3", "busy after start", int'(busy), 1);
    check("R3", "cmd_ready while waiting", int'(cmd_ready), 1);
    check("R3", "cs_n while waiting", int'(cs_n), 1);
    wr(16'h0505);
    check("R10", "clear while waiting", int'(busy), 0);

    // directed delay cases, including the zero-field extremes
    full_xfer(4, 4, 1'b1, 1'b1, 16'hA5C3, 16'h3C5A);
    full_xfer(0, 0, 1'b1, 1'b1, 16'h8001, 16'hFFFF);
    full_xfer(1, 1, 1'b1, 1'b1, 16'h0000, 16'h8000);
    full_xfer(127, 255, 1'b1, 1'b1, 16'hFFFF, 16'h0001);
    full_xfer(90, 200, 1'b0, 1'b0, 16'h1234, 16'hFEDC);

    // constrained random transfers
    for (int i = 0; i < 24; i++) begin
      int lf, tf;
      lf = (i % 6 == 0) ? 0 : int'($urandom_range(1, 127));
      tf = (i % 6 == 3) ? 0 : int'($urandom_range(1, 255));
      full_xfer(lf, tf, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                16'($urandom), 16'($urandom));
    end

    // R10 abort in the middle of shifting
    prev_rx = rx_word;
    wr(16'h9407);
    launch(1'b1, 1'b1, 16'hC0DE, 16'h5555, hs);
    while (rises < 5) tick();
    wr(16'h1407);
    check("R10", "cs_n after abort", int'(cs_n), 1);
    check("R10", "sclk after abort", int'(sclk), 0);
    check("R10", "busy after abort", int'(busy), 0);
    repeat (40) tick();
    check("R10", "rx_valid after abort", rxv_cnt, 0);
    check("R10", "rx_word kept", int'(rx_word), int'(prev_rx));
    check("R10", "cs_n stays high", int'(cs_n), 1);

    // R11 clear under the lock: ignored, new trail field taken
    abort_lock = 1'b1;
    wr(16'h8309);
    launch(1'b1, 1'b1, 16'h6B2D, 16'h9A61, hs);
    while (rises < 3) tick();
    wr(16'h030C);
    check("R11", "busy under lock", int'(busy), 1);
    check("R11", "stored word under lock", int'(reg_rdata), 16'h830C);
    while (busy) tick();
    tick();
    abort_lock = 1'b0;
    check("R11", "rx_word after locked clear", int'(rx_word), 16'h9A61);
    check("R11", "trail uses new field", bfall_cyc - rise_cyc, 12);
    check("R11", "mosi word", int'(mosi_cap), 16'h6B2D);

    // R12 set write held across the edge that ends the trail delay
    wr(16'h8305);
    launch(1'b1, 1'b1, 16'h0F0F, 16'h7E81, hs);
    while (cs_n) tick();
    do tick(); while (!cs_n || rises < 16);
    repeat (4) tick();
    check("R12", "busy before collision", int'(busy), 1);
    wr(16'h8305);
    check("R12", "busy after collision", int'(busy), 1);
    check("R12", "cmd_ready after collision", int'(cmd_ready), 1);
    check("R12", "received word", int'(rx_word), 16'h7E81);
    wr(16'h0305);
    check("R12", "released afterwards", int'(busy), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL R9 watchdog expired: actual busy=%0d expected 0", busy);
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

endmodule